// File: doc/BRIEF.md
# Fixed-Angle Vector Rotation Pipeline

This block turns a stream of 2-D signed fixed-point vectors through one angle that is chosen when the block is elaborated. The angle is not an input. It is encoded as a chain of stages that run one after the other. Each stage either applies a micro-rotation by an arctangent of a power of two, or multiplies both coordinates by a factor of the form (1 ± 2^-s). The scaling stages cancel the gain that the micro-rotations build up. Every stage has a shift amount that is wired in, and each of its adders always adds or always subtracts. As a result, the logic between two registers is one adder and nothing else.

The pipeline accepts one vector on each clock and returns it NSTAGE cycles later. A valid flag travels with the data, and there is no backpressure. The default configuration has seven stages:

- four counter-clockwise micro-rotations with shifts 1, 3, 5 and 7, which together turn the vector by about 35.93°;
- three scaling stages that multiply by (1 − 2^-3), (1 + 2^-6) and (1 − 2^-9).

With these stages the overall gain is within about 0.02 % of one.

Top module: `rot_cascade`

## Requirements
- R1: A synchronous active-high `rst` clears every stage's valid flag and data register. In the first cycle after reset is released, `out_valid` is 0 and `out_x`/`out_y` are 0. Inputs presented while `rst` is high are discarded.
- R2: `out_valid` equals `in_valid` delayed by exactly NSTAGE clock cycles, with one register per stage.
- R3: A new vector is accepted on every cycle. Back-to-back valid inputs give back-to-back valid outputs in the same order, with no stall.
- R4: A rotation stage with shift s and direction bit 0 computes X' = X − (Y >>> s) and Y' = Y + (X >>> s). With direction bit 1 it computes X' = X + (Y >>> s) and Y' = Y − (X >>> s). Here >>> is an arithmetic right shift that rounds toward minus infinity, and every result is wrapped to COORD_W bits in two's complement.
- R5: A scaling stage with shift s computes X' = X + (X >>> s) and Y' = Y + (Y >>> s) when its direction bit is 0, and X' = X − (X >>> s) and Y' = Y − (Y >>> s) when it is 1. It uses the same shift and wrap rules as R4.
- R6: The stages are configured as follows. Stage i's shift is the 8-bit field `SHIFT_VEC[8*i +: 8]`, its direction bit is `SUB_VEC[i]`, and its type is `KIND_VEC[i]` (1 = scaling, 0 = rotation). Stage 0 acts first and stage NSTAGE−1 acts last.
- R7: A stage's data register loads only in a cycle whose input valid is high. During bubbles, `out_x`/`out_y` keep the last result that was delivered.
- R8: With the default tables, no stage overflows COORD_W bits for inputs whose coordinates satisfy |x|, |y| < 2^(COORD_W−3).
- R9: With the default tables, the input (4096, 0) comes out at about (3316, 2404), to within 12 LSB. This is a counter-clockwise turn of about 35.9° with unit gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector present this cycle |
| in_x | input | COORD_W | Input X, signed |
| in_y | input | COORD_W | Input Y, signed |
| out_valid | output | 1 | Output vector present this cycle |
| out_x | output | COORD_W | Rotated X, signed |
| out_y | output | COORD_W | Rotated Y, signed |

## Verification
The overflow assertions assume that both input coordinates stay below 2^(COORD_W−3) in magnitude. The arithmetic wraps silently, so an input outside that range would produce a wrong result without any sign of error. Every random and corner stimulus is therefore drawn from [−8191, 8191], and the extreme corners of that range are applied explicitly. The hold and reset assertions assume that `rst` is an ordinary synchronous signal. The bench raises it in the middle of a stream to show that vectors still in flight are dropped.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int COORD_W = 16;
    localparam int WIDE_W  = COORD_W + 1;

    typedef logic signed [COORD_W-1:0] coord_t;
    typedef logic signed [WIDE_W-1:0]  wide_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } vec_t;

    // One guard bit above the stored width, used to detect overflow.
    typedef struct packed {
        wide_t x;
        wide_t y;
    } wvec_t;

    typedef enum logic {
        STG_ROTATE = 1'b0,
        STG_SCALE  = 1'b1
    } stage_kind_e;

    function automatic wide_t widen(input coord_t v);
        return {v[COORD_W-1], v};
    endfunction

    function automatic wide_t wide_asr(input coord_t v, input int s);
        return widen(coord_t'(v >>> s));
    endfunction

endpackage

// File: rtl/rc_rot_core.sv
module rc_rot_core
    import rc_pkg::*;
#(
    parameter int SHIFT = 1,
    parameter bit SUB   = 1'b0
) (
    input  vec_t  a,
    output wvec_t r
);
    wide_t wx, wy, sx, sy;

    always_comb begin
        wx = widen(a.x);
        wy = widen(a.y);
        sx = wide_asr(a.y, SHIFT);   // cross-coupled operand for X
        sy = wide_asr(a.x, SHIFT);   // cross-coupled operand for Y
    end

    generate
        if (SUB) begin : g_cw
            assign r.x = wx + sx;
            assign r.y = wy - sy;
        end else begin : g_ccw
            assign r.x = wx - sx;
            assign r.y = wy + sy;
        end
    endgenerate
endmodule

// File: rtl/rc_scale_core.sv
module rc_scale_core
    import rc_pkg::*;
#(
    parameter int SHIFT = 3,
    parameter bit SUB   = 1'b0
) (
    input  vec_t  a,
    output wvec_t r
);
    wide_t wx, wy, sx, sy;

    always_comb begin
        wx = widen(a.x);
        wy = widen(a.y);
        sx = wide_asr(a.x, SHIFT);   // own-coordinate operand
        sy = wide_asr(a.y, SHIFT);
    end

    generate
        if (SUB) begin : g_shrink
            assign r.x = wx - sx;
            assign r.y = wy - sy;
        end else begin : g_grow
            assign r.x = wx + sx;
            assign r.y = wy + sy;
        end
    endgenerate
endmodule

// File: rtl/rc_stage.sv
module rc_stage
    import rc_pkg::*;
#(
    parameter int          SHIFT = 1,
    parameter bit          SUB   = 1'b0,
    parameter stage_kind_e KIND  = STG_ROTATE
) (
    input  logic clk,
    input  logic rst,
    input  logic vld_i,
    input  vec_t d_i,
    output logic vld_o,
    output vec_t d_o
);
    wvec_t nxt;

    generate
        if (KIND == STG_SCALE) begin : g_scale
            rc_scale_core #(.SHIFT(SHIFT), .SUB(SUB)) u_core (.a(d_i), .r(nxt));
        end else begin : g_rot
            rc_rot_core #(.SHIFT(SHIFT), .SUB(SUB)) u_core (.a(d_i), .r(nxt));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            d_o   <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                d_o.x <= nxt.x[COORD_W-1:0];
                d_o.y <= nxt.y[COORD_W-1:0];
            end
        end
    end

    // R8: the guard bit agrees with the sign bit whenever a result is taken
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        vld_i |-> (nxt.x[COORD_W] == nxt.x[COORD_W-1]) &&
                  (nxt.y[COORD_W] == nxt.y[COORD_W-1]));

    // R7: a bubble leaves the stage data untouched
    a_r7_hold_on_bubble: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(d_o));

    // R1: leaving reset, the stage is empty and zeroed
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vld_o && d_o == '0));
endmodule

// File: rtl/rot_cascade.sv
module rot_cascade
    import rc_pkg::*;
#(
    parameter int                   NSTAGE    = 7,
    parameter logic [NSTAGE*8-1:0]  SHIFT_VEC = {8'd9, 8'd6, 8'd3, 8'd7, 8'd5, 8'd3, 8'd1},
    parameter logic [NSTAGE-1:0]    SUB_VEC   = 7'b1010000,
    parameter logic [NSTAGE-1:0]    KIND_VEC  = 7'b1110000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    output logic               out_valid,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y
);
    localparam int LAST = NSTAGE;

    vec_t chain_d [LAST+1];
    logic chain_v [LAST+1];

    assign chain_v[0]   = in_valid;
    assign chain_d[0].x = in_x;
    assign chain_d[0].y = in_y;

    generate
        for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_stage
            rc_stage #(
                .SHIFT(int'(SHIFT_VEC[gi*8 +: 8])),
                .SUB  (SUB_VEC[gi]),
                .KIND (stage_kind_e'(KIND_VEC[gi]))
            ) u_stage (
                .clk  (clk),
                .rst  (rst),
                .vld_i(chain_v[gi]),
                .d_i  (chain_d[gi]),
                .vld_o(chain_v[gi+1]),
                .d_o  (chain_d[gi+1])
            );

            // R2: a valid flag at a stage output came from its predecessor one cycle earlier
            a_r2_valid_chain: assert property (@(posedge clk) disable iff (rst)
                chain_v[gi+1] |-> $past(chain_v[gi]));
        end
    endgenerate

    assign out_valid = chain_v[LAST];
    assign out_x     = chain_d[LAST].x;
    assign out_y     = chain_d[LAST].y;
endmodule

// File: tb/tb_rot_cascade.sv
module tb_rot_cascade;
    localparam int N = 7;
    localparam int W = 16;
    // Own stage tables, stage 0 first: shift, subtract flag, scale flag
    localparam int SH [N] = '{1, 3, 5, 7, 3, 6, 9};
    localparam int SB [N] = '{0, 0, 0, 0, 1, 0, 1};
    localparam int SC [N] = '{0, 0, 0, 0, 1, 1, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] in_x = '0, in_y = '0;
    logic out_valid;
    logic [W-1:0] out_x, out_y;

    always #10 clk = ~clk;   // 50 MHz

    rot_cascade dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
    );

    typedef struct { int v; int x; int y; } exp_t;
    exp_t q[$];
    int tests = 0, fails = 0;
    int px = 0, py = 0;
    bit finished = 0;

    function automatic int wrap(input int v);
        return ((v + 32768) & 65535) - 32768;
    endfunction

    // Behavioural model of R4/R5 under the R6 table layout
    task automatic model(input int xi, input int yi, output int xo, output int yo);
        int x = xi, y = yi, nx, ny;
        for (int i = 0; i < N; i++) begin
            if (SC[i] == 1) begin
                nx = (SB[i] == 1) ? x - (x >>> SH[i]) : x + (x >>> SH[i]);
                ny = (SB[i] == 1) ? y - (y >>> SH[i]) : y + (y >>> SH[i]);
            end else begin
                nx = (SB[i] == 1) ? x + (y >>> SH[i]) : x - (y >>> SH[i]);
                ny = (SB[i] == 1) ? y - (x >>> SH[i]) : y + (x >>> SH[i]);
            end
            x = wrap(nx);
            y = wrap(ny);
        end
        xo = x; yo = y;
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sample();
        exp_t e = q.pop_front();
        int ax = int'($signed(out_x));
        int ay = int'($signed(out_y));
        check("R2 out_valid latency", int'(out_valid), e.v);
        if (e.v != 0) begin
            check("R4 R5 out_x", ax, e.x);
            check("R4 R5 out_y", ay, e.y);
        end else begin
            check("R7 out_x hold", ax, e.x);
            check("R7 out_y hold", ay, e.y);
        end
    endtask

    task automatic cyc(input bit v, input int x, input int y);
        exp_t e;
        int mx, my;
        @(negedge clk);
        sample();
        rst = 1'b0;
        in_valid = v;
        in_x = W'(x);
        in_y = W'(y);
        if (v) begin
            model(x, y, mx, my);
            px = mx; py = my;
            e = '{1, mx, my};
        end else begin
            e = '{0, px, py};
        end
        q.push_back(e);
    endtask

    // R1: reset in mid-stream drops everything in flight
    task automatic reset_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sample();
            rst = 1'b1;
            in_valid = 1'b1;
            in_x = W'(1234);
            in_y = W'(-777);
            foreach (q[j]) q[j] = '{0, 0, 0};
            px = 0; py = 0;
            q.push_back('{0, 0, 0});
        end
    endtask

    function automatic int rnd();
        return int'($urandom_range(16382)) - 8191;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) q.push_back('{0, 0, 0});
        repeat (3) @(posedge clk);
        // R1: the first samples after release show the cleared state
        cyc(0, 0, 0);
        cyc(1, 0, 0);
        cyc(1, 8191, 0);
        cyc(1, 0, 8191);
        cyc(1, -8191, -8191);
        cyc(1, 8191, -8191);
        cyc(1, -8191, 8191);
        cyc(1, -1, -1);
        cyc(1, 1, 0);
        // R9: known angle and gain
        cyc(1, 4096, 0);
        for (int k = 0; k < N - 1; k++) cyc(0, 0, 0);
        cyc(0, 0, 0);
        tests++;
        if ($signed(out_x) < 3304 || $signed(out_x) > 3328 ||
            $signed(out_y) < 2392 || $signed(out_y) > 2416) begin
            fails++;
            $display("FAIL R9: actual (%0d,%0d) expected (3316,2404) +-12",
                     $signed(out_x), $signed(out_y));
        end
        // R3: back-to-back random stream
        for (int k = 0; k < 400; k++) cyc(1, rnd(), rnd());
        // R7: bubbles interleaved
        for (int k = 0; k < 300; k++) cyc(($urandom_range(1) == 1), rnd(), rnd());
        // R1: reset while vectors are in flight
        for (int k = 0; k < 5; k++) cyc(1, rnd(), rnd());
        reset_cycles(2);
        for (int k = 0; k < N + 2; k++) cyc(0, 0, 0);
        for (int k = 0; k < 100; k++) cyc(1, rnd(), rnd());
        for (int k = 0; k < N + 2; k++) cyc(0, 0, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule